// File: doc/BRIEF.md
# LFSR-Sequenced Program Counter

This block is the program counter of a small 4-bit controller core. The address is split into a page number in the upper bits and a 6-bit offset in the lower bits. When the counter advances, the offset does not count in binary. It steps through a 64-state shift-register sequence, so the gate cost is a single shift and one feedback bit rather than a carry chain. The page bits stay as they are. Straight-line code therefore runs through one page in the order of that sequence.

The surrounding core selects one of three operations on each cycle: advance, replace the offset (a short branch), or load the whole address (a call or a return). It can also issue a page prefix. The prefix latches a page number that replaces the page field one cycle later, on top of whatever that cycle's operation produced. The address width is a parameter, 10 or 11 bits, which gives a 4-bit or 5-bit page field.

Top module: `lfsr_pc`

## Requirements
- R1: While `rst_n` is sampled low, the counter goes to all ones across its full width and any pending page prefix is cleared.
- R2: An advance changes only the 6 offset bits. The page bits (bits ADDR_W-1 down to 6) keep their value.
- R3: An advance shifts the offset left by one, drops the old bit 5, and puts a feedback bit into bit 0. The feedback bit is 1 when offset bit 4 equals offset bit 5, and 0 when they differ.
- R4: Two offsets override the feedback rule. 0x1F forces feedback 1, so the next offset is 0x3F. 0x3F forces feedback 0, so the next offset is 0x3E.
- R5: Starting from offset 0, 64 advances visit every one of the 64 offset values exactly once and return to 0.
- R6: `ld_low_i` replaces the offset with `low_i` and keeps the page. It takes priority over `step_i`.
- R7: `ld_full_i` loads `addr_i` into the whole counter. It takes priority over `ld_low_i` and `step_i`.
- R8: `page_set_i` latches `page_i`. On the next clock edge, and only on that edge, the page field of the result becomes the latched page. The offset bits come from that cycle's operation (advance, offset load, full load or hold). A new `page_set_i` on that edge latches a new prefix.
- R9: With no operation and no pending prefix, the counter holds its value.
- R10: The latched page is masked to the page width. With ADDR_W = 10, bit 4 of `page_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Advance the offset one step in the sequence |
| ld_low_i | input | 1 | Load the offset from `low_i` |
| low_i | input | 6 | New offset for a short branch |
| ld_full_i | input | 1 | Load the whole counter from `addr_i` |
| addr_i | input | ADDR_W | New address for a call or a return |
| page_set_i | input | 1 | Page prefix: latch `page_i` for the next cycle |
| page_i | input | PAGE_IN_W | Page number carried by the prefix |
| pc_o | output | ADDR_W | Current program counter |

## Verification
The bench builds two copies of the block from the same stimulus: one with ADDR_W = 11 (5-bit page) and one with ADDR_W = 10 (4-bit page). Running both copies together shows two things. First, the page prefix keeps or drops bit 4 of the page value depending on width. Second, the reset value of all ones and the advance sequence do not depend on the page width. Directed sequences cover the two forced feedback offsets, the full 64-step walk from offset 0, and a prefix that lands in the same cycle as each kind of load. A long stretch of random operations then exercises every priority combination against the reference model.

// File: rtl/lfsr_pc_pkg.sv
// Shared definitions for the LFSR-sequenced program counter.
// Assumes the offset field is at least 3 bits wide; the default is 6.
package lfsr_pc_pkg;

    // Operation selected for the current cycle, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOW  = 2'd2,
        OP_FULL = 2'd3
    } pc_op_e;

endpackage

// File: rtl/pc_op_decode.sv
// Priority decoder for the counter operations.
// Full load wins over offset load, and offset load wins over advance.
// Assumes the request inputs are stable around the clock edge.
module pc_op_decode
    import lfsr_pc_pkg::*;
(
    input  logic   step_i,
    input  logic   ld_low_i,
    input  logic   ld_full_i,
    output pc_op_e op_o
);

    // Choose the highest-priority active request.
    always_comb begin
        if (ld_full_i)      op_o = OP_FULL;
        else if (ld_low_i)  op_o = OP_LOW;
        else if (step_i)    op_o = OP_STEP;
        else                op_o = OP_HOLD;
    end

endmodule

// File: rtl/pc_low_lfsr.sv
// Next-state logic for the offset field: a left shift with one feedback bit.
// The feedback bit is normally the XNOR of the top two bits. The half-full
// pattern (0 followed by ones) forces it to 1 and the all-ones pattern forces
// it to 0. Together these give a single 2^LOW_W cycle.
// Purely combinational; assumes LOW_W >= 3.
module pc_low_lfsr #(
    parameter int LOW_W = 6
) (
    input  logic [LOW_W-1:0] cur_i,
    output logic [LOW_W-1:0] nxt_o
);

    localparam logic [LOW_W-1:0] ALL_ONES  = '1;
    localparam logic [LOW_W-1:0] HALF_ONES = ALL_ONES >> 1;

    logic fb;

    // Pick the feedback bit, applying the two forced cases.
    always_comb begin
        if (cur_i == HALF_ONES)     fb = 1'b1;
        else if (cur_i == ALL_ONES) fb = 1'b0;
        else                        fb = (cur_i[LOW_W-2] == cur_i[LOW_W-1]);
    end

    // Shift left, dropping the top bit and inserting the feedback bit.
    assign nxt_o = {cur_i[LOW_W-2:0], fb};

endmodule

// File: rtl/pc_page_prefix.sv
// Holds a page prefix for exactly one cycle.
// When set_i is sampled high, page_i (masked to PAGE_W bits) is latched and
// pend_o goes high for the next cycle. pend_o stays high only if set_i is
// sampled high again. Assumes PAGE_W <= PAGE_IN_W.
module pc_page_prefix #(
    parameter int PAGE_W    = 5,
    parameter int PAGE_IN_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_i,
    input  logic [PAGE_IN_W-1:0] page_i,
    output logic                 pend_o,
    output logic [PAGE_W-1:0]    page_o
);

    // Capture the prefix and arm it for a single following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            page_o <= '0;
        end else begin
            pend_o <= set_i;
            if (set_i) page_o <= page_i[PAGE_W-1:0];
        end
    end

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i |=> !pend_o);

endmodule

// File: rtl/lfsr_pc.sv
// Program counter with a page field and a shift-register offset field.
// Each cycle it applies one operation (full load, offset load, advance or
// hold), then replaces the page field if a page prefix was given on the
// previous cycle. Assumes 10 <= ADDR_W and PAGE_W <= PAGE_IN_W.
module lfsr_pc
    import lfsr_pc_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int LOW_W     = 6,
    parameter int PAGE_IN_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_i,
    input  logic                 ld_low_i,
    input  logic [LOW_W-1:0]     low_i,
    input  logic                 ld_full_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 page_set_i,
    input  logic [PAGE_IN_W-1:0] page_i,
    output logic [ADDR_W-1:0]    pc_o
);

    localparam int PAGE_W = ADDR_W - LOW_W;

    pc_op_e             op;
    logic [LOW_W-1:0]   low_adv;
    logic               pend;
    logic [PAGE_W-1:0]  pend_page;
    logic [ADDR_W-1:0]  pc_q;
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  pc_d;

    pc_op_decode u_dec (
        .step_i    (step_i),
        .ld_low_i  (ld_low_i),
        .ld_full_i (ld_full_i),
        .op_o      (op)
    );

    pc_low_lfsr #(.LOW_W(LOW_W)) u_lfsr (
        .cur_i (pc_q[LOW_W-1:0]),
        .nxt_o (low_adv)
    );

    pc_page_prefix #(.PAGE_W(PAGE_W), .PAGE_IN_W(PAGE_IN_W)) u_pfx (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (page_set_i),
        .page_i (page_i),
        .pend_o (pend),
        .page_o (pend_page)
    );

    // Result of this cycle's operation, before any page substitution.
    always_comb begin
        case (op)
            OP_FULL: base = addr_i;
            OP_LOW:  base = {pc_q[ADDR_W-1:LOW_W], low_i};
            OP_STEP: base = {pc_q[ADDR_W-1:LOW_W], low_adv};
            default: base = pc_q;
        endcase
    end

    // Apply a pending page prefix on top of the operation result.
    assign pc_d = pend ? {pend_page, base[LOW_W-1:0]} : base;

    // Counter register; reset loads all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '1;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

    // R2
    step_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ld_low_i && !ld_full_i && !pend)
        |=> pc_o[ADDR_W-1:LOW_W] == $past(pc_o[ADDR_W-1:LOW_W]));

    // R6
    low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_low_i && !ld_full_i) |=> pc_o[LOW_W-1:0] == $past(low_i));

    // R7
    full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_full_i && !pend) |=> pc_o == $past(addr_i));

    // R8
    page_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> pc_o[ADDR_W-1:LOW_W] == $past(pend_page));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !ld_low_i && !ld_full_i && !pend) |=> $stable(pc_o));

endmodule

// File: tb/sim_lfsr_pc.sv
`timescale 1ns/1ps
module sim_lfsr_pc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, ld_low_i = 1'b0, ld_full_i = 1'b0, page_set_i = 1'b0;
    logic [5:0]  low_i = '0;
    logic [10:0] addr_i = '0;
    logic [4:0]  page_i = '0;
    logic [10:0] pc0;
    logic [9:0]  pc1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state: index 0 is the 11-bit copy, index 1 the 10-bit copy.
    int m_pc[2];
    bit m_pend[2];
    int m_page[2];

    always #2.5 clk = ~clk;

    lfsr_pc #(.ADDR_W(11)) u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .ld_low_i(ld_low_i),
        .low_i(low_i), .ld_full_i(ld_full_i), .addr_i(addr_i),
        .page_set_i(page_set_i), .page_i(page_i), .pc_o(pc0));

    lfsr_pc #(.ADDR_W(10)) u1 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .ld_low_i(ld_low_i),
        .low_i(low_i), .ld_full_i(ld_full_i), .addr_i(addr_i[9:0]),
        .page_set_i(page_set_i), .page_i(page_i), .pc_o(pc1));

    // Offset sequence as stated in R3 and R4.
    function automatic int ref_adv(int v);
        int fb;
        fb = (((v >> 4) & 1) == ((v >> 5) & 1)) ? 1 : 0;
        if (v == 31) fb = 1;
        if (v == 63) fb = 0;
        return ((v * 2) + fb) % 64;
    endfunction

    // Compare one copy against its expectation and count the check.
    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle, advance both models, and compare both copies after the edge.
    task automatic cycle(bit st, bit ll, int lo, bit lf, int ad, bit ps, int pg);
        string tag[2];
        @(negedge clk);
        step_i = st; ld_low_i = ll; low_i = lo[5:0]; ld_full_i = lf;
        addr_i = ad[10:0]; page_set_i = ps; page_i = pg[4:0];
        for (int k = 0; k < 2; k++) begin
            int w, mask, r, lowv, pagev;
            w = (k == 0) ? 11 : 10;
            mask = (1 << w) - 1;
            lowv = m_pc[k] % 64;
            pagev = m_pc[k] / 64;
            if (lf) begin r = ad & mask; tag[k] = "R7"; end
            else if (ll) begin r = pagev * 64 + lo; tag[k] = "R6"; end
            else if (st) begin
                r = pagev * 64 + ref_adv(lowv);
                tag[k] = (lowv == 31 || lowv == 63) ? "R4" : "R3/R2";
            end
            else begin r = m_pc[k]; tag[k] = "R9"; end
            if (m_pend[k]) begin
                r = (m_page[k] * 64 + (r % 64)) & mask;
                tag[k] = (k == 1) ? "R10/R8" : "R8";
            end
            m_pc[k] = r;
            m_pend[k] = ps;
            if (ps) m_page[k] = pg & ((1 << (w - 6)) - 1);
        end
        @(posedge clk);
        #1;
        check({tag[0], " w11"}, int'(pc0), m_pc[0]);
        check({tag[1], " w10"}, int'(pc1), m_pc[1]);
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [63:0] seen;
        int uniq;
        // R1: reset gives all ones and no pending prefix.
        page_set_i = 1'b1; page_i = 5'h3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        page_set_i = 1'b0;
        rst_n = 1'b1;
        m_pc[0] = 11'h7FF; m_pc[1] = 10'h3FF;
        m_pend[0] = 0; m_pend[1] = 0; m_page[0] = 0; m_page[1] = 0;
        #0.5;
        check("R1 w11", int'(pc0), 'h7FF);
        check("R1 w10", int'(pc1), 'h3FF);
        idle();                       // R1: prefix set during reset is not applied
        // R4: forced cases, from 0x3F (after reset) and from 0x1F.
        cycle(1, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 1, 'h29F, 0, 0);
        cycle(1, 0, 0, 0, 0, 0, 0);
        cycle(1, 0, 0, 0, 0, 0, 0);
        // R6 and R7: priority combinations.
        cycle(1, 1, 'h15, 0, 0, 0, 0);
        cycle(1, 1, 'h2A, 1, 'h123, 0, 0);
        // R5: 64-step walk from offset 0.
        cycle(0, 0, 0, 1, 'h2C0, 0, 0);
        seen = '0; uniq = 0;
        for (int i = 0; i < 64; i++) begin
            if (!seen[pc0[5:0]]) uniq++;
            seen[pc0[5:0]] = 1'b1;
            cycle(1, 0, 0, 0, 0, 0, 0);
        end
        check("R5 distinct offsets", uniq, 64);
        check("R5 return to 0", int'(pc0[5:0]), 0);
        // R8 and R10: prefix with each operation in the following cycle.
        cycle(0, 0, 0, 0, 0, 1, 'h1A);
        cycle(1, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 1, 'h05);
        cycle(0, 1, 'h11, 0, 0, 1, 'h13);
        cycle(0, 0, 0, 1, 'h7C3, 0, 0);
        cycle(0, 0, 0, 0, 0, 1, 'h1F);
        idle();
        idle();                       // R8: prefix applies once only
        // Random mix of all operations.
        for (int i = 0; i < 400; i++) begin
            int v;
            v = $urandom;
            cycle(v[0], v[1] & v[2], (v >> 3) & 63, v[9] & v[10] & v[11],
                  (v >> 12) & 'h7FF, v[23] & v[24], (v >> 25) & 31);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule